// File: doc/BRIEF.md
# Fractional PLL Output Frequency Calculator

This block works out the output frequency of a phase-locked loop from the reference clock frequency and the divider settings programmed into it. A request carries a 32-bit reference frequency in Hz, a feedback divider, a reference divider, two post-dividers, a 24-bit fractional feedback value and three control bits. The answer is a 32-bit frequency in Hz together with an error flag. Firmware models and clock-tree monitors use the block when they need the true rate without reading a table.

Every step is sequential and uses 64-bit intermediates. One shift-add multiplier and one restoring divider do all the work, and the divider produces one quotient bit per clock. In the default format the integer product is divided by the reference divider. In fractional mode a second product, reference times fraction, is also divided by the reference divider, scaled by 2^-24 and added to it. The sum then passes through the first post-divider and then the second, with truncation at each division. A second format takes every field as its stored value plus one and uses a single output divider. A bypass request returns the reference frequency unchanged.

Requests use a valid/ready handshake. `in_ready` is high only while the block is idle, so a request offered while it is busy is held off and has no effect. The result leaves as a one-cycle `out_valid` pulse. The output has no back-pressure, so the consumer must take the result in that cycle. `out_hz` and `out_err` keep their values until the next result.

Top module: `fpll_freq_calc`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` is 0, and `out_hz` and `out_err` are 0.
- R2: A request is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the edge after acceptance until the cycle after the `out_valid` pulse. `in_valid` has no effect while `in_ready` is 0. Each accepted request gives exactly one `out_valid` pulse.
- R3: With `plus_one_fmt`=0, `int_mode`=1 and `bypass`=0, the result is floor(floor(floor(ref*fb/rd)/pd1)/pd2), taken to its low 32 bits. `frac` is ignored.
- R4: With `plus_one_fmt`=0, `int_mode`=0 and `bypass`=0, the term floor(floor(ref*frac/rd)/2^24) is added to floor(ref*fb/rd) before the two post-divisions.
- R5: With `plus_one_fmt`=1 and `bypass`=0, the result is floor(floor(ref*(fb+1)/(rd+1))/(pd1+1)). `pd2`, `frac` and `int_mode` are ignored, and `out_err` is 0.
- R6: With `bypass`=1, the result equals `ref_hz` and `out_err` is 0, whatever the divider fields hold, zeros included.
- R7: With `plus_one_fmt`=0 and `bypass`=0, a value of zero in `ref_div`, `post_div1` or `post_div2` gives `out_hz`=0 and `out_err`=1, and the result still arrives.
- R8: `out_valid` lasts exactly one cycle. `out_hz` and `out_err` change only in a cycle where `out_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Block idle, request can be accepted |
| ref_hz | input | 32 | Reference frequency in Hz |
| fb_div | input | 12 | Feedback divider field |
| ref_div | input | 6 | Reference divider field |
| post_div1 | input | 3 | First post-divider field |
| post_div2 | input | 3 | Second post-divider field |
| frac | input | 24 | Fractional feedback value, in units of 2^-24 |
| int_mode | input | 1 | 1: integer feedback, fraction ignored |
| plus_one_fmt | input | 1 | 1: fields stored minus one, single output divider |
| bypass | input | 1 | 1: result is the reference frequency |
| out_valid | output | 1 | One-cycle result strobe |
| out_hz | output | 32 | Computed frequency in Hz |
| out_err | output | 1 | Zero divisor detected |

## Verification
The hardest condition to reach is a new request that arrives while a long multi-division computation is still running. The stimulus holds `in_valid` high with different operands during that busy window. The clock-by-clock model then shows that `in_ready` stays low, that no extra pulse appears and that the result belongs to the first request. The zero-divisor and bypass cases are driven with zeros in every divider field, so that the bypass priority is seen from the ports. A fractional case with a half-unit fraction is chosen so that the 2^-24 scaling shows up in the result.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MUL_INT,
    ST_DIV_INT,
    ST_MUL_FRAC,
    ST_DIV_FRAC,
    ST_DIV_P1,
    ST_DIV_P2,
    ST_DONE
  } fpc_state_e;
endpackage

// File: rtl/fpc_mul.sv
// Shift-add multiplier: one multiplier bit per clock, B_W clocks per product.
module fpc_mul #(
  parameter int A_W = 64,
  parameter int B_W = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [A_W-1:0] a,
  input  logic [B_W-1:0] b,
  output logic           done,
  output logic [A_W-1:0] prod
);
  localparam int CNT_W = $clog2(B_W + 1);

  logic [A_W-1:0]   acc, sh_a;
  logic [B_W-1:0]   sh_b;
  logic [CNT_W-1:0] cnt;
  logic             run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc  <= '0;
      sh_a <= '0;
      sh_b <= '0;
      cnt  <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else if (start) begin
      acc  <= '0;
      sh_a <= a;
      sh_b <= b;
      cnt  <= CNT_W'(B_W);
      run  <= 1'b1;
      done <= 1'b0;
    end else if (run) begin
      if (sh_b[0]) acc <= acc + sh_a;
      sh_a <= sh_a << 1;
      sh_b <= sh_b >> 1;
      cnt  <= cnt - 1'b1;
      if (cnt == CNT_W'(1)) begin
        run  <= 1'b0;
        done <= 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end

  assign prod = acc;
endmodule

// File: rtl/fpc_div.sv
// Restoring shift-subtract divider: one quotient bit per clock, W clocks.
module fpc_div #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quot
);
  localparam int CNT_W = $clog2(W + 1);

  logic [W:0]       rem, rem_sh, diff;
  logic [W-1:0]     quo, dvs;
  logic [CNT_W-1:0] cnt;
  logic             run, ge;

  always_comb begin
    rem_sh = {rem[W-1:0], quo[W-1]};
    diff   = rem_sh - {1'b0, dvs};
    ge     = (rem_sh >= {1'b0, dvs});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem  <= '0;
      quo  <= '0;
      dvs  <= '0;
      cnt  <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else if (start) begin
      rem  <= '0;
      quo  <= dividend;
      dvs  <= divisor;
      cnt  <= CNT_W'(W);
      run  <= 1'b1;
      done <= 1'b0;
    end else if (run) begin
      rem <= ge ? diff : rem_sh;
      quo <= {quo[W-2:0], ge};
      cnt <= cnt - 1'b1;
      if (cnt == CNT_W'(1)) begin
        run  <= 1'b0;
        done <= 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end

  assign quot = quo;
endmodule

// File: rtl/fpll_freq_calc.sv
module fpll_freq_calc #(
  parameter int REF_W  = 32,
  parameter int FB_W   = 12,
  parameter int RD_W   = 6,
  parameter int PD_W   = 3,
  parameter int FRAC_W = 24,
  parameter int ACC_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [REF_W-1:0]  ref_hz,
  input  logic [FB_W-1:0]   fb_div,
  input  logic [RD_W-1:0]   ref_div,
  input  logic [PD_W-1:0]   post_div1,
  input  logic [PD_W-1:0]   post_div2,
  input  logic [FRAC_W-1:0] frac,
  input  logic              int_mode,
  input  logic              plus_one_fmt,
  input  logic              bypass,
  output logic              out_valid,
  output logic [REF_W-1:0]  out_hz,
  output logic              out_err
);
  import fpc_pkg::*;

  localparam int MB_W = (FRAC_W > FB_W + 1) ? FRAC_W : FB_W + 1;

  fpc_state_e        state;
  logic              kick;
  logic [REF_W-1:0]  r_ref;
  logic [FB_W-1:0]   r_fb;
  logic [RD_W-1:0]   r_rd;
  logic [PD_W-1:0]   r_p1, r_p2;
  logic [FRAC_W-1:0] r_frac;
  logic              r_int, r_p1f;
  logic [ACC_W-1:0]  sum;

  logic [FB_W:0]     fb_eff;
  logic [RD_W:0]     rd_eff;
  logic [PD_W:0]     p1_eff, p2_eff;
  logic              use_frac, in_zero;

  logic              mul_start, mul_done, div_start, div_done;
  logic [MB_W-1:0]   mul_b;
  logic [ACC_W-1:0]  mul_prod, div_a, div_b, div_q;

  // effective divider values for the captured request
  always_comb begin
    fb_eff   = r_p1f ? ({1'b0, r_fb} + 1'b1) : {1'b0, r_fb};
    rd_eff   = r_p1f ? ({1'b0, r_rd} + 1'b1) : {1'b0, r_rd};
    p1_eff   = r_p1f ? ({1'b0, r_p1} + 1'b1) : {1'b0, r_p1};
    p2_eff   = {1'b0, r_p2};
    use_frac = !r_p1f && !r_int;
    in_zero  = !plus_one_fmt &&
               ((ref_div == '0) || (post_div1 == '0) || (post_div2 == '0));
  end

  // operand steering for the shared arithmetic units
  always_comb begin
    mul_b = (state == ST_MUL_FRAC) ? MB_W'(r_frac) : MB_W'(fb_eff);
    div_a = sum;
    div_b = ACC_W'(rd_eff);
    case (state)
      ST_DIV_INT, ST_DIV_FRAC: div_a = mul_prod;
      ST_DIV_P1:               div_b = ACC_W'(p1_eff);
      ST_DIV_P2:               div_b = ACC_W'(p2_eff);
      default: ;
    endcase
    mul_start = kick && ((state == ST_MUL_INT) || (state == ST_MUL_FRAC));
    div_start = kick && ((state == ST_DIV_INT) || (state == ST_DIV_FRAC) ||
                         (state == ST_DIV_P1)  || (state == ST_DIV_P2));
  end

  fpc_mul #(.A_W(ACC_W), .B_W(MB_W)) u_mul (
    .clk(clk), .rst_n(rst_n), .start(mul_start),
    .a(ACC_W'(r_ref)), .b(mul_b), .done(mul_done), .prod(mul_prod)
  );

  fpc_div #(.W(ACC_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start),
    .dividend(div_a), .divisor(div_b), .done(div_done), .quot(div_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      kick   <= 1'b0;
      r_ref  <= '0;
      r_fb   <= '0;
      r_rd   <= '0;
      r_p1   <= '0;
      r_p2   <= '0;
      r_frac <= '0;
      r_int  <= 1'b0;
      r_p1f  <= 1'b0;
      sum    <= '0;
      out_hz <= '0;
      out_err <= 1'b0;
    end else begin
      kick <= 1'b0;
      case (state)
        ST_IDLE: if (in_valid) begin
          r_ref  <= ref_hz;
          r_fb   <= fb_div;
          r_rd   <= ref_div;
          r_p1   <= post_div1;
          r_p2   <= post_div2;
          r_frac <= frac;
          r_int  <= int_mode;
          r_p1f  <= plus_one_fmt;
          if (bypass) begin
            out_hz  <= ref_hz;
            out_err <= 1'b0;
            state   <= ST_DONE;
          end else if (in_zero) begin
            out_hz  <= '0;
            out_err <= 1'b1;
            state   <= ST_DONE;
          end else begin
            state <= ST_MUL_INT;
            kick  <= 1'b1;
          end
        end
        ST_MUL_INT: if (mul_done) begin
          state <= ST_DIV_INT;
          kick  <= 1'b1;
        end
        ST_DIV_INT: if (div_done) begin
          sum   <= div_q;
          state <= use_frac ? ST_MUL_FRAC : ST_DIV_P1;
          kick  <= 1'b1;
        end
        ST_MUL_FRAC: if (mul_done) begin
          state <= ST_DIV_FRAC;
          kick  <= 1'b1;
        end
        ST_DIV_FRAC: if (div_done) begin
          sum   <= sum + (div_q >> FRAC_W);
          state <= ST_DIV_P1;
          kick  <= 1'b1;
        end
        ST_DIV_P1: if (div_done) begin
          if (r_p1f) begin
            out_hz  <= div_q[REF_W-1:0];
            out_err <= 1'b0;
            state   <= ST_DONE;
          end else begin
            sum   <= div_q;
            state <= ST_DIV_P2;
            kick  <= 1'b1;
          end
        end
        ST_DIV_P2: if (div_done) begin
          out_hz  <= div_q[REF_W-1:0];
          out_err <= 1'b0;
          state   <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_DONE);
endmodule

// File: rtl/fpll_freq_calc_chk.sv
module fpll_freq_calc_chk #(
  parameter int REF_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic [REF_W-1:0] out_hz,
  input logic             out_err
);
  // R8: result strobe lasts a single cycle
  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R8: outputs only move together with the strobe
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |=> (out_valid || ($stable(out_hz) && $stable(out_err))));

  // R2: acceptance makes the block busy on the next cycle
  p_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R2: not ready while presenting a result, ready right after
  p_nready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  p_ready_after_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> in_ready);

  // R7: an error result carries a zero frequency
  p_err_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_hz == '0));
endmodule

bind fpll_freq_calc fpll_freq_calc_chk #(.REF_W(REF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_hz(out_hz), .out_err(out_err)
);

// File: tb/sim_fpll_freq_calc.sv
`timescale 1ns/1ps
module sim_fpll_freq_calc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] ref_hz = '0;
  logic [11:0] fb_div = '0;
  logic [5:0]  ref_div = '0;
  logic [2:0]  post_div1 = '0, post_div2 = '0;
  logic [23:0] frac = '0;
  logic        int_mode = 1'b0, plus_one_fmt = 1'b0, bypass = 1'b0;
  logic        out_valid;
  logic [31:0] out_hz;
  logic        out_err;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  fpll_freq_calc u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .ref_hz(ref_hz), .fb_div(fb_div), .ref_div(ref_div),
    .post_div1(post_div1), .post_div2(post_div2), .frac(frac),
    .int_mode(int_mode), .plus_one_fmt(plus_one_fmt), .bypass(bypass),
    .out_valid(out_valid), .out_hz(out_hz), .out_err(out_err)
  );

  task automatic chk(input string req, input longint unsigned got,
                     input longint unsigned exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // behavioural model of one request: bit 32 is the error flag
  function automatic longint unsigned model(
      input longint unsigned r, input longint unsigned fb,
      input longint unsigned rd, input longint unsigned p1,
      input longint unsigned p2, input longint unsigned fr,
      input bit im, input bit pf, input bit bp);
    longint unsigned v;
    if (bp) return r;
    if (pf) begin
      v = (r * (fb + 1)) / (rd + 1);
      v = v / (p1 + 1);
      return v & 64'hFFFF_FFFF;
    end
    if (rd == 0 || p1 == 0 || p2 == 0) return 64'h1_0000_0000;
    v = (r * fb) / rd;
    if (!im) v = v + (((r * fr) / rd) >> 24);
    v = v / p1;
    v = v / p2;
    return v & 64'hFFFF_FFFF;
  endfunction

  // reference model state, compared every clock at the falling edge
  longint unsigned exp_q[$];
  bit              busy = 1'b0;
  logic [31:0]     last_hz = '0;
  logic            last_err = 1'b0;

  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      chk("R2 ready", in_ready, !busy);
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          chk("R2 extra pulse", 1, 0);
        end else begin
          longint unsigned e;
          e = exp_q.pop_front();
          chk("R3-7 result hz", out_hz, e & 64'hFFFF_FFFF);
          chk("R3-7 result err", out_err, e >> 32);
        end
        last_hz  = out_hz;
        last_err = out_err;
        busy = 1'b0;
      end else begin
        chk("R8 hold hz", out_hz, last_hz);
        chk("R8 hold err", out_err, last_err);
      end
      if (in_valid && in_ready) begin
        exp_q.push_back(model(ref_hz, fb_div, ref_div, post_div1, post_div2,
                              frac, int_mode, plus_one_fmt, bypass));
        busy = 1'b1;
      end
    end
  end

  task automatic send(input logic [31:0] r, input logic [11:0] fb,
                      input logic [5:0] rd, input logic [2:0] p1,
                      input logic [2:0] p2, input logic [23:0] fr,
                      input bit im, input bit pf, input bit bp);
    bit ok;
    ref_hz = r; fb_div = fb; ref_div = rd; post_div1 = p1; post_div2 = p2;
    frac = fr; int_mode = im; plus_one_fmt = pf; bypass = bp;
    in_valid = 1'b1;
    forever begin
      ok = in_ready;
      @(posedge clk); #1;
      if (ok) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (busy || exp_q.size() != 0) begin
      @(posedge clk); #1;
    end
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 ready", in_ready, 1);
    chk("R1 valid", out_valid, 0);
    chk("R1 hz", out_hz, 0);
    chk("R1 err", out_err, 0);
    @(posedge clk); #1;

    // R3: integer mode, fraction present but ignored
    send(32'd24_000_000, 12'd100, 6'd1, 3'd2, 3'd1, 24'hABCDEF, 1, 0, 0);
    drain();
    // R3: truncation at every division
    send(32'd24_000_000, 12'd125, 6'd3, 3'd7, 3'd3, 24'd0, 1, 0, 0);
    drain();
    // R3: result taken to 32 bits
    send(32'hFFFF_FFFF, 12'd4095, 6'd1, 3'd1, 3'd1, 24'd0, 1, 0, 0);
    drain();
    // R4: half-unit fraction adds ref*0.5
    send(32'd24_000_000, 12'd50, 6'd1, 3'd1, 3'd1, 24'h800000, 0, 0, 0);
    drain();
    // R4: odd dividers with fraction
    send(32'd26_000_000, 12'd33, 6'd5, 3'd3, 3'd2, 24'h123456, 0, 0, 0);
    drain();
    // R4: zero fraction matches integer mode
    send(32'd25_000_000, 12'd40, 6'd2, 3'd2, 3'd2, 24'd0, 0, 0, 0);
    drain();
    // R5: plus-one format, post_div2 of zero ignored
    send(32'd24_000_000, 12'd63, 6'd1, 3'd1, 3'd0, 24'hFFFFFF, 0, 1, 0);
    drain();
    // R5: all-zero fields mean divide by one
    send(32'd27_000_000, 12'd0, 6'd0, 3'd0, 3'd5, 24'd7, 1, 1, 0);
    drain();
    // R6: bypass with zero dividers
    send(32'd19_200_000, 12'd0, 6'd0, 3'd0, 3'd0, 24'd0, 0, 0, 1);
    drain();
    // R7: each zero divisor
    send(32'd24_000_000, 12'd100, 6'd0, 3'd1, 3'd1, 24'd0, 1, 0, 0);
    drain();
    send(32'd24_000_000, 12'd100, 6'd1, 3'd0, 3'd1, 24'd0, 1, 0, 0);
    drain();
    send(32'd24_000_000, 12'd100, 6'd1, 3'd1, 3'd0, 24'd0, 0, 0, 0);
    drain();
    // R2: a request held while busy must be ignored
    send(32'd12_000_000, 12'd200, 6'd1, 3'd4, 3'd1, 24'h400000, 0, 0, 0);
    ref_hz = 32'd1; fb_div = 12'd1; ref_div = 6'd1; bypass = 1'b1;
    in_valid = 1'b1;
    while (busy) begin
      @(posedge clk); #1;
      if (out_valid) break;
    end
    in_valid = 1'b0;
    drain();
    // R2: back-to-back requests
    send(32'd24_000_000, 12'd99, 6'd1, 3'd1, 3'd1, 24'd0, 1, 0, 0);
    send(32'd24_000_000, 12'd98, 6'd1, 3'd1, 3'd1, 24'd0, 1, 0, 0);
    drain();

    done_flag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    done_flag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule